// File: doc/BRIEF.md
# Serial Port Register Front End with Banked Baud Divisor

This block puts eight byte-wide registers in front of a basic asynchronous serial transmitter and receiver. A host reaches them over a simple bus: a 3-bit offset, one write strobe and one read strobe, and 8-bit data in each direction. Writes take effect on the rising clock edge. Read data is combinational from the offset.

The top bit of the line-format register selects which registers appear at offsets 0 and 1. When that bit is clear, offset 0 is the data register and offset 1 is the interrupt mask. When it is set, offsets 0 and 1 become the low and high bytes of a 16-bit baud divisor. The divisor sets the period of an oversampling tick: one tick every divisor clocks, and 16 ticks per serial bit. A probe routine can check that the device is present by writing the divisor and reading it back.

The transmitter has one holding register and one shift register. The receiver shares the tick. It captures one character and raises a data-ready flag. A loopback control bit keeps the external line idle and feeds the transmit stream straight into the receiver.

Top module: `sp_top`

## Requirements
- R1: After reset, offsets 1, 3 and 4 read 0x00, the status register at offset 5 reads 0x60, txOut is 1, and dtrN and rtsN are 1.
- R2: With line-format bit 7 set, offsets 0 and 1 write and read the low and high divisor bytes exactly as written (for example 0x5A and 0xA5). With bit 7 clear, offset 1 is the interrupt mask: its low 4 bits are writable and its upper 4 bits read 0.
- R3: A write to offset 0 while bit 7 is set leaves the transmitter untouched: status stays 0x60 and txOut stays 1.
- R4: Offset 2 always reads 0x01 (no interrupt pending), and a write to offset 2 does not change that. Offsets 6 and 7 read 0x00.
- R5: Offset 4 stores bits 4:0 and reads its upper 3 bits as 0. dtrN is the inverse of bit 0 and rtsN is the inverse of bit 1.
- R6: Status bit 5 (holding register empty) reads 0 in the cycle after a data write and returns to 1 one cycle later, when the byte moves to the shift register. Status bit 6 is 1 only when both the holding register and the shifter are empty.
- R7: Each character is sent as one low start bit, then 5 + (line-format bits 1:0) data bits LSB first, then one high stop bit. Every bit lasts 16 ticks, and a tick occurs every divisor clocks.
- R8: With a divisor of 0 the tick stops and a frame in progress freezes. Loading a non-zero divisor lets the frame finish.
- R9: With offset-4 bit 4 set, txOut stays 1 and the transmitted frame enters the receiver. Once the frame ends, status bit 0 is 1 and offset 0 reads the character right-aligned to the word length.
- R10: Reading offset 0 with line-format bit 7 clear clears status bit 0.
- R11: A data write in the same cycle that the transmitter takes the previous byte is kept, and both characters go out in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (side effects only) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr |
| txOut | output | 1 | Serial output, idle high |
| rxIn | input | 1 | Serial input, idle high |
| dtrN | output | 1 | Active-low terminal-ready output |
| rtsN | output | 1 | Active-low request-to-send output |

## Verification
Two things can happen in the same cycle: a host write to the data register, and the transmitter moving the previous byte out of the holding register. The bench forces this by writing two bytes on consecutive clock edges. The second write then lands exactly on the edge where the idle transmitter takes the first byte. A scoreboard decodes txOut at mid-bit and expects both characters in write order, so losing either byte or swapping them shows up as a mismatch or as a leftover entry in the queue.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DIV_W  = 2 * DATA_W;
  localparam int OVS    = 16;
  localparam int SUB_W  = $clog2(OVS);
  localparam int BIT_W  = $clog2(DATA_W);

  typedef struct packed {
    logic wrThr;
    logic wrIer;
    logic wrDll;
    logic wrDlm;
    logic wrLcr;
    logic wrMcr;
    logic rdRbr;
  } hostStb_t;

  typedef enum logic [3:0] {
    SEL_RBR, SEL_IER, SEL_DLL, SEL_DLM, SEL_IIR,
    SEL_LCR, SEL_MCR, SEL_LSR, SEL_MSR, SEL_NONE
  } rdSel_t;

  typedef enum logic [1:0] {LN_IDLE, LN_START, LN_DATA, LN_STOP} lineState_t;
endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              dlab,
  output hostStb_t          stb,
  output rdSel_t            rdSel
);
  always_comb begin
    stb   = '0;
    rdSel = SEL_NONE;
    case (addr)
      3'd0: begin
        if (dlab) begin
          stb.wrDll = wrEn;
          rdSel     = SEL_DLL;
        end else begin
          stb.wrThr = wrEn;
          stb.rdRbr = rdEn;
          rdSel     = SEL_RBR;
        end
      end
      3'd1: begin
        if (dlab) begin
          stb.wrDlm = wrEn;
          rdSel     = SEL_DLM;
        end else begin
          stb.wrIer = wrEn;
          rdSel     = SEL_IER;
        end
      end
      3'd2: rdSel = SEL_IIR;
      3'd3: begin
        stb.wrLcr = wrEn;
        rdSel     = SEL_LCR;
      end
      3'd4: begin
        stb.wrMcr = wrEn;
        rdSel     = SEL_MCR;
      end
      3'd5: rdSel = SEL_LSR;
      3'd6: rdSel = SEL_MSR;
      default: rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import sp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hostStb_t          stb,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxIn,
  output logic              dlab,
  output logic [DATA_W-1:0] rdData,
  output logic              txOut,
  output logic              dtrN,
  output logic              rtsN
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

  logic [DATA_W-1:0] lcr, dll, dlm, thr, rbr, txShift, rxShift;
  logic [4:0]        mcr;
  logic [3:0]        ier;
  logic              thrEmpty, dataReady;
  logic [DIV_W-1:0]  divisor, baudCnt;
  logic              tick;
  lineState_t        txState, rxState;
  logic [SUB_W-1:0]  txSub, rxSub;
  logic [BIT_W-1:0]  txBit, rxBit, lastBit;
  logic              txLine, rxLine, rxDone, loopOn;

  assign dlab    = lcr[DATA_W-1];
  assign loopOn  = mcr[4];
  assign divisor = {dlm, dll};
  assign lastBit = BIT_W'(4) + BIT_W'(lcr[1:0]);

  // host-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lcr <= '0; mcr <= '0; ier <= '0; dll <= '0; dlm <= '0;
    end else begin
      if (stb.wrLcr) lcr <= wrData;
      if (stb.wrMcr) mcr <= wrData[4:0];
      if (stb.wrIer) ier <= wrData[3:0];
      if (stb.wrDll) dll <= wrData;
      if (stb.wrDlm) dlm <= wrData;
    end
  end

  // oversampling tick
  assign tick = (divisor != '0) && (baudCnt >= divisor - DIV_W'(1));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     baudCnt <= '0;
    else if (tick || divisor == '0) baudCnt <= '0;
    else           baudCnt <= baudCnt + DIV_W'(1);
  end

  // holding register: a host write wins over the transfer in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thr <= '0; thrEmpty <= 1'b1;
    end else if (stb.wrThr) begin
      thr <= wrData; thrEmpty <= 1'b0;
    end else if (txState == LN_IDLE && !thrEmpty) begin
      thrEmpty <= 1'b1;
    end
  end

  // transmitter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= LN_IDLE; txSub <= '0; txBit <= '0; txShift <= '0;
    end else begin
      case (txState)
        LN_IDLE: if (!thrEmpty) begin
          txShift <= thr; txSub <= '0; txState <= LN_START;
        end
        LN_START: if (tick) begin
          txSub <= txSub + SUB_W'(1);
          if (txSub == SUB_LAST) begin txState <= LN_DATA; txBit <= '0; end
        end
        LN_DATA: if (tick) begin
          txSub <= txSub + SUB_W'(1);
          if (txSub == SUB_LAST) begin
            txShift <= txShift >> 1;
            if (txBit == lastBit) txState <= LN_STOP;
            else                  txBit <= txBit + BIT_W'(1);
          end
        end
        default: if (tick) begin
          txSub <= txSub + SUB_W'(1);
          if (txSub == SUB_LAST) txState <= LN_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    case (txState)
      LN_START: txLine = 1'b0;
      LN_DATA:  txLine = txShift[0];
      default:  txLine = 1'b1;
    endcase
  end

  assign txOut  = loopOn ? 1'b1 : txLine;
  assign rxLine = loopOn ? txLine : rxIn;
  assign dtrN   = ~mcr[0];
  assign rtsN   = ~mcr[1];

  // receiver
  assign rxDone = (rxState == LN_STOP) && tick && (rxSub == SUB_LAST);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= LN_IDLE; rxSub <= '0; rxBit <= '0; rxShift <= '0; rbr <= '0;
    end else if (tick) begin
      case (rxState)
        LN_IDLE: if (!rxLine) begin rxState <= LN_START; rxSub <= '0; end
        LN_START: begin
          rxSub <= rxSub + SUB_W'(1);
          if (rxSub == SUB_MID) begin
            rxSub <= '0; rxBit <= '0;
            rxState <= rxLine ? LN_IDLE : LN_DATA;
          end
        end
        LN_DATA: begin
          rxSub <= rxSub + SUB_W'(1);
          if (rxSub == SUB_LAST) begin
            rxShift <= {rxLine, rxShift[DATA_W-1:1]};
            if (rxBit == lastBit) rxState <= LN_STOP;
            else                  rxBit <= rxBit + BIT_W'(1);
          end
        end
        default: begin
          rxSub <= rxSub + SUB_W'(1);
          if (rxSub == SUB_LAST) begin
            rbr <= rxShift >> (2'd3 - lcr[1:0]);
            rxState <= LN_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          dataReady <= 1'b0;
    else if (rxDone)    dataReady <= 1'b1;
    else if (stb.rdRbr) dataReady <= 1'b0;
  end

  // read mux
  always_comb begin
    case (rdSel)
      SEL_RBR: rdData = rbr;
      SEL_IER: rdData = {4'b0, ier};
      SEL_DLL: rdData = dll;
      SEL_DLM: rdData = dlm;
      SEL_IIR: rdData = 8'h01;
      SEL_LCR: rdData = lcr;
      SEL_MCR: rdData = {3'b0, mcr};
      SEL_LSR: rdData = {1'b0, thrEmpty && txState == LN_IDLE, thrEmpty, 4'b0, dataReady};
      default: rdData = '0;
    endcase
  end

  // R6: a data write empties nothing and fills the holding register
  p_thr_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrThr |=> !thrEmpty);
  // R6: an idle transmitter takes a waiting byte on the next edge
  p_shift_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    (txState == LN_IDLE && !thrEmpty && !stb.wrThr) |=> (thrEmpty && txState == LN_START));
  // R8: with no divisor the frame in flight is frozen
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == '0 && txState != LN_IDLE) |=> ($stable(txState) && $stable(txSub)));
  // R9: a completed character raises data-ready
  p_dr_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> dataReady);
  // R10: reading the data register drops data-ready
  p_dr_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdRbr && !rxDone) |=> !dataReady);
endmodule

// File: rtl/sp_top.sv
module sp_top
  import sp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              txOut,
  input  logic              rxIn,
  output logic              dtrN,
  output logic              rtsN
);
  hostStb_t stb;
  rdSel_t   rdSel;
  logic     dlab;

  sp_ctrl u_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .dlab(dlab),
    .stb(stb), .rdSel(rdSel)
  );

  sp_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .wrData(wrData),
    .rxIn(rxIn), .dlab(dlab), .rdData(rdData), .txOut(txOut),
    .dtrN(dtrN), .rtsN(rtsN)
  );
endmodule

// File: tb/tb_sp_top.sv
module tb_sp_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       txOut, dtrN, rtsN;
  logic       rxIn = 1'b1;

  int nChecks = 0, nFails = 0;
  int bitCycles = 16;
  int wordLen = 8;
  bit monOn = 1'b1;
  bit finished = 1'b0;
  logic [7:0] expQ[$];

  always #4 clk = ~clk;

  sp_top dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .txOut(txOut), .rxIn(rxIn),
    .dtrN(dtrN), .rtsN(rtsN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    addr = a; rdEn = 1'b0;
    #1 v = rdData;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    expQ.push_back(d & 8'((1 << wordLen) - 1));
    wr(3'd0, d);
  endtask

  task automatic setDiv(input logic [15:0] dv, input logic [7:0] lcrVal);
    wr(3'd3, lcrVal | 8'h80);
    wr(3'd0, dv[7:0]);
    wr(3'd1, dv[15:8]);
    wr(3'd3, lcrVal);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // scoreboard monitor for frames on txOut
  initial begin
    forever begin
      @(negedge clk);
      if (monOn && rstN && txOut == 1'b0) begin
        logic [7:0] got;
        got = '0;
        repeat (bitCycles / 2 - 1) @(negedge clk);
        check(txOut == 1'b0, "R7 start bit", txOut, 0);
        for (int i = 0; i < wordLen; i++) begin
          repeat (bitCycles) @(negedge clk);
          got[i] = txOut;
        end
        repeat (bitCycles) @(negedge clk);
        check(txOut == 1'b1, "R7 stop bit", txOut, 1);
        if (expQ.size() == 0) check(1'b0, "R11 unexpected frame", got, 0);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(got == e, "R7/R11 frame data", got, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(3'd3, v); check(v == 8'h00, "R1 line format", v, 8'h00);
    peek(3'd4, v); check(v == 8'h00, "R1 modem ctl", v, 8'h00);
    peek(3'd1, v); check(v == 8'h00, "R1 int mask", v, 8'h00);
    peek(3'd5, v); check(v == 8'h60, "R1 status", v, 8'h60);
    check(txOut && dtrN && rtsN, "R1 pins", {txOut, dtrN, rtsN}, 3'b111);

    // R2 divisor banking and probe pattern
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h5A); peek(3'd0, v); check(v == 8'h5A, "R2 div low 5A", v, 8'h5A);
    wr(3'd0, 8'hA5); peek(3'd0, v); check(v == 8'hA5, "R2 div low A5", v, 8'hA5);
    wr(3'd1, 8'h3C); peek(3'd1, v); check(v == 8'h3C, "R2 div high", v, 8'h3C);
    // R3 divisor write does not touch the transmitter
    peek(3'd5, v); check(v == 8'h60, "R3 status after div write", v, 8'h60);
    check(txOut == 1'b1, "R3 line idle", txOut, 1);
    wr(3'd1, 8'h00); wr(3'd0, 8'h01);
    wr(3'd3, 8'h03);
    wr(3'd1, 8'hFF); peek(3'd1, v); check(v == 8'h0F, "R2 int mask bank", v, 8'h0F);
    wr(3'd3, 8'h83); peek(3'd1, v); check(v == 8'h00, "R2 div high kept", v, 8'h00);
    peek(3'd0, v); check(v == 8'h01, "R2 div low kept", v, 8'h01);
    wr(3'd3, 8'h03);

    // R4 offset 2 and unused offsets
    peek(3'd2, v); check(v == 8'h01, "R4 ident", v, 8'h01);
    wr(3'd2, 8'h00); peek(3'd2, v); check(v == 8'h01, "R4 ident after fifo write", v, 8'h01);
    peek(3'd6, v); check(v == 8'h00, "R4 offset 6", v, 8'h00);
    peek(3'd7, v); check(v == 8'h00, "R4 offset 7", v, 8'h00);

    // R5 modem control
    wr(3'd4, 8'hEF); peek(3'd4, v); check(v == 8'h0F, "R5 modem readback", v, 8'h0F);
    check(!dtrN && !rtsN, "R5 pins low", {dtrN, rtsN}, 0);
    wr(3'd4, 8'h02); check(dtrN && !rtsN, "R5 rts only", {dtrN, rtsN}, 2'b10);
    wr(3'd4, 8'h03);

    // R6 / R7 single character
    send(8'h5A);
    peek(3'd5, v); check(v == 8'h00, "R6 status after write", v, 8'h00);
    @(negedge clk);
    peek(3'd5, v); check(v == 8'h20, "R6 status shifter busy", v, 8'h20);
    repeat (200) @(negedge clk);
    peek(3'd5, v); check(v == 8'h60, "R6 status drained", v, 8'h60);

    // R11 back-to-back writes collide with the transfer
    send(8'hA3);
    send(8'h3C);
    repeat (400) @(negedge clk);
    check(expQ.size() == 0, "R11 both frames seen", expQ.size(), 0);

    // R7 five-bit word
    wr(3'd3, 8'h00); wordLen = 5;
    send(8'hF5);
    repeat (200) @(negedge clk);
    wr(3'd3, 8'h03); wordLen = 8;

    // R7 divisor 2
    setDiv(16'd2, 8'h03); bitCycles = 32;
    send(8'hC3);
    repeat (400) @(negedge clk);
    setDiv(16'd1, 8'h03); bitCycles = 16;
    check(expQ.size() == 0, "R7 frames drained", expQ.size(), 0);

    // R8 zero divisor freezes
    monOn = 1'b0;
    setDiv(16'd0, 8'h03);
    wr(3'd0, 8'h81);
    repeat (100) @(negedge clk);
    check(txOut == 1'b0, "R8 frozen in start bit", txOut, 0);
    peek(3'd5, v); check(v == 8'h20, "R8 status frozen", v, 8'h20);
    setDiv(16'd1, 8'h03);
    repeat (200) @(negedge clk);
    check(txOut == 1'b1, "R8 frame finished", txOut, 1);
    peek(3'd5, v); check(v == 8'h60, "R8 status after resume", v, 8'h60);

    // R9 loopback
    wr(3'd4, 8'h13);
    wr(3'd0, 8'h6B);
    repeat (40) @(negedge clk);
    check(txOut == 1'b1, "R9 line held idle", txOut, 1);
    repeat (200) @(negedge clk);
    peek(3'd5, v); check(v == 8'h61, "R9 data ready", v, 8'h61);
    rd(3'd0, v); check(v == 8'h6B, "R9 received byte", v, 8'h6B);
    peek(3'd5, v); check(v == 8'h60, "R10 ready cleared", v, 8'h60);

    wr(3'd3, 8'h00);
    wr(3'd0, 8'hF5);
    repeat (240) @(negedge clk);
    rd(3'd0, v); check(v == 8'h15, "R9 five-bit received", v, 8'h15);
    peek(3'd5, v); check(v[0] == 1'b0, "R10 ready cleared again", v[0], 0);
    wr(3'd3, 8'h03);
    wr(3'd4, 8'h03);

    finished = 1'b1;
    report();
  end
endmodule